// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Bank

This block watches one bank of already-synchronized input pins and turns chosen transitions into interrupt requests. Each pin carries a two-bit trigger code that selects rising-edge, falling-edge or both-edge detection, or switches detection off. Level-sensitive triggering is not offered. A detected edge sets a sticky per-pin event flag. The flags stay set until software writes a one to them, and an edge that lands after a flag was cleared sets it again, so no event is dropped.

Each pin also has a mask bit. Software sets mask bits through one write address and clears them through a second, so it never needs a read-modify-write. Masking gates only the bank interrupt line: event flags keep latching on masked pins. The interrupt line is high for as long as any unmasked flag is set. The register write port is a plain valid-qualified strobe with no back-pressure: the block accepts a write in every cycle that `wr_valid` is high. The pin and trigger inputs are sampled on every clock.

Top module: `gpio_edge_irq`

## Requirements
- R1: While reset is asserted and right after it is released, every event flag is 0, every mask bit is 1 and `irq_o` is 0.
- R2: Trigger code 1 (`trig_i[2i+1:2i]` = 2'b01) sets the pin's flag on a 0-to-1 pin transition. A 1-to-0 transition does not set it.
- R3: Trigger code 2 sets the pin's flag on a 1-to-0 transition. A 0-to-1 transition does not set it.
- R4: Trigger code 3 sets the pin's flag on a transition in either direction. Each pin follows its own code, independently of the other pins.
- R5: With trigger code 0, no transition sets the pin's flag.
- R6: A write to the flag address (`STAT_OFS + 4*BANK`) clears each flag whose data bit is 1 and leaves the other flags unchanged. A flag appears on `status_o` one clock after its edge.
- R7: A write to the mask-set address (`MSET_OFS + 4*BANK`) sets each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R8: A write to the mask-clear address (`MCLR_OFS + 4*BANK`) clears each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R9: `irq_o` equals the OR over all pins of (flag AND NOT mask). It stays high until every unmasked flag has been cleared or masked.
- R10: Flags latch edges on masked pins. Unmasking a pin whose flag is already set raises `irq_o`.
- R11: If an edge is detected in the same cycle as a write-one-to-clear of that flag, the flag ends up set.
- R12: After its flag is cleared, a pin's next qualifying edge sets the flag again.
- R13: A write to any other address changes neither flags nor masks. The pin level present when reset is released is not counted as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Synchronized pin levels |
| trig_i | input | 2*NPINS | Per-pin trigger code, two bits per pin, pin i at [2i+1:2i] |
| wr_valid | input | 1 | Register write strobe, always accepted |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | NPINS | Register write data, one bit per pin |
| status_o | output | NPINS | Sticky edge event flags |
| mask_o | output | NPINS | Mask bits, 1 = pin masked |
| irq_o | output | 1 | Bank interrupt request |

## Verification
The assertions assume that `pin_i` is already synchronous to `clk` and holds one value for each whole cycle. They also assume that the trigger codes are stable across the edge where they are sampled, so that the edge detector's hit vector is the only source of new flags. The bench meets these assumptions by changing pins, trigger codes and write strobes only on the falling clock edge, and it never drives an unknown level. Its write addresses are either one of the three decoded addresses or addresses known to be undecoded.

// File: rtl/gpio_eirq_pkg.sv
package gpio_eirq_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_e;

  // Decide whether one pin transition qualifies under the given trigger code.
  function automatic logic edge_hit(input trig_e code, input logic prev, input logic cur);
    logic rise;
    logic fall;
    rise = ~prev & cur;
    fall = prev & ~cur;
    case (code)
      TRIG_RISE: edge_hit = rise;
      TRIG_FALL: edge_hit = fall;
      TRIG_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_eirq_decode.sv
module gpio_eirq_decode #(
  parameter int NPINS    = 32,
  parameter int ADDR_W   = 12,
  parameter int BANK     = 0,
  parameter int STAT_OFS = 'h080,
  parameter int MSET_OFS = 'h0A0,
  parameter int MCLR_OFS = 'h0C0
) (
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NPINS-1:0]  wr_data,
  output logic [NPINS-1:0]  stat_clr,
  output logic [NPINS-1:0]  mask_set,
  output logic [NPINS-1:0]  mask_clr
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS + 4 * BANK);
  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(MSET_OFS + 4 * BANK);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(MCLR_OFS + 4 * BANK);

  logic hit_stat, hit_mset, hit_mclr;

  always_comb begin
    hit_stat = wr_valid && (wr_addr == A_STAT);
    hit_mset = wr_valid && (wr_addr == A_MSET);
    hit_mclr = wr_valid && (wr_addr == A_MCLR);
    stat_clr = hit_stat ? wr_data : '0;
    mask_set = hit_mset ? wr_data : '0;
    mask_clr = hit_mclr ? wr_data : '0;
  end
endmodule

// File: rtl/gpio_eirq_edge.sv
module gpio_eirq_edge
  import gpio_eirq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   pin_i,
  input  logic [2*NPINS-1:0] trig_i,
  output logic [NPINS-1:0]   hit_o
);
  logic             primed_q;
  logic [NPINS-1:0] prev_q;

  // The first sampled level after reset only seeds the history.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= pin_i[i];
    end
    assign hit_o[i] = primed_q & edge_hit(trig_e'(trig_i[2*i +: 2]), prev_q[i], pin_i[i]);
  end
endmodule

// File: rtl/gpio_eirq_core.sv
module gpio_eirq_core #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] hit,
  input  logic [NPINS-1:0] stat_clr,
  input  logic [NPINS-1:0] mask_set,
  input  logic [NPINS-1:0] mask_clr,
  output logic [NPINS-1:0] status_o,
  output logic [NPINS-1:0] mask_o,
  output logic             irq_o
);
  logic [NPINS-1:0] stat_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | hit;     // a new edge beats the clear
      mask_q <= (mask_q | mask_set) & ~mask_clr;
    end
  end

  assign status_o = stat_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(stat_q & ~mask_q);
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NPINS    = 32,
  parameter int ADDR_W   = 12,
  parameter int BANK     = 0,
  parameter int STAT_OFS = 'h080,
  parameter int MSET_OFS = 'h0A0,
  parameter int MCLR_OFS = 'h0C0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   pin_i,
  input  logic [2*NPINS-1:0] trig_i,
  input  logic               wr_valid,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [NPINS-1:0]   wr_data,
  output logic [NPINS-1:0]   status_o,
  output logic [NPINS-1:0]   mask_o,
  output logic               irq_o
);
  logic [NPINS-1:0] hit_w, stat_clr_w, mask_set_w, mask_clr_w;

  gpio_eirq_edge #(.NPINS(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .trig_i(trig_i), .hit_o(hit_w)
  );

  gpio_eirq_decode #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .BANK(BANK),
    .STAT_OFS(STAT_OFS), .MSET_OFS(MSET_OFS), .MCLR_OFS(MCLR_OFS)
  ) u_dec (
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .stat_clr(stat_clr_w), .mask_set(mask_set_w), .mask_clr(mask_clr_w)
  );

  gpio_eirq_core #(.NPINS(NPINS)) u_core (
    .clk(clk), .rst_n(rst_n), .hit(hit_w), .stat_clr(stat_clr_w),
    .mask_set(mask_set_w), .mask_clr(mask_clr_w),
    .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int NPINS    = 32,
  parameter int ADDR_W   = 12,
  parameter int BANK     = 0,
  parameter int STAT_OFS = 'h080,
  parameter int MSET_OFS = 'h0A0,
  parameter int MCLR_OFS = 'h0C0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*NPINS-1:0] trig_i,
  input logic               wr_valid,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [NPINS-1:0]   wr_data,
  input logic [NPINS-1:0]   hit,
  input logic [NPINS-1:0]   status_o,
  input logic [NPINS-1:0]   mask_o,
  input logic               irq_o
);
  localparam logic [ADDR_W-1:0] C_STAT = ADDR_W'(STAT_OFS + 4 * BANK);
  localparam logic [ADDR_W-1:0] C_MSET = ADDR_W'(MSET_OFS + 4 * BANK);
  localparam logic [ADDR_W-1:0] C_MCLR = ADDR_W'(MCLR_OFS + 4 * BANK);

  logic             is_stat, is_mset, is_mclr;
  logic [NPINS-1:0] clr_v, off_v;

  always_comb begin
    is_stat = wr_valid && (wr_addr == C_STAT);
    is_mset = wr_valid && (wr_addr == C_MSET);
    is_mclr = wr_valid && (wr_addr == C_MCLR);
    clr_v   = is_stat ? wr_data : '0;
    for (int i = 0; i < NPINS; i++) off_v[i] = (trig_i[2*i +: 2] == 2'd0);
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (status_o == '0 && mask_o == '1 && !irq_o)); // R1
  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & off_v) == '0); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v != '0) |=> ((status_o & $past(clr_v) & ~$past(hit)) == '0)); // R6
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    is_mset |=> ((mask_o & $past(wr_data)) == $past(wr_data))); // R7
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    is_mclr |=> ((mask_o & $past(wr_data)) == '0)); // R8
  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(is_stat || is_mset)); // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_o != '0)); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_o) & ~$past(clr_v) & ~status_o) == '0)); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((status_o & $past(hit)) == $past(hit))); // R11
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_mset || is_mclr) |=> $stable(mask_o)); // R13
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .BANK(BANK),
  .STAT_OFS(STAT_OFS), .MSET_OFS(MSET_OFS), .MCLR_OFS(MCLR_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .wr_valid(wr_valid),
  .wr_addr(wr_addr), .wr_data(wr_data), .hit(hit_w),
  .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
);

// File: tb/tb_gpio_edge_irq.sv
module tb_gpio_edge_irq;
  localparam int N  = 32;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_ST = 12'h080;
  localparam logic [AW-1:0] A_MS = 12'h0A0;
  localparam logic [AW-1:0] A_MC = 12'h0C0;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [N-1:0] pin, wd;
  logic [2*N-1:0] trig;
  logic wv;
  logic [AW-1:0] wa;
  logic [N-1:0] st_o, mk_o;
  logic irq;

  gpio_edge_irq dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .trig_i(trig), .wr_valid(wv),
    .wr_addr(wa), .wr_data(wd), .status_o(st_o), .mask_o(mk_o), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  logic [N-1:0] m_stat, m_mask, m_prev;
  bit m_primed;

  task automatic chk(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "status", st_o, m_stat);
    chk(tag, "mask", mk_o, m_mask);
    chk(tag, "irq", N'(irq), N'(|(m_stat & ~m_mask)));
  endtask

  // Called at a falling edge: drive, model one rising edge, check at next falling edge.
  task automatic cyc(string tag, logic [N-1:0] p, logic v, logic [AW-1:0] a, logic [N-1:0] d);
    logic [N-1:0] h, clr, ms, mc;
    pin = p; wv = v; wa = a; wd = d;
    for (int i = 0; i < N; i++) begin
      logic r, f;
      logic [1:0] c;
      c = trig[2*i +: 2];
      r = !m_prev[i] && p[i];
      f = m_prev[i] && !p[i];
      h[i] = m_primed && ((c == 2'd1 && r) || (c == 2'd2 && f) || (c == 2'd3 && (r || f)));
    end
    clr = (v && a == A_ST) ? d : '0;
    ms  = (v && a == A_MS) ? d : '0;
    mc  = (v && a == A_MC) ? d : '0;
    m_stat = (m_stat & ~clr) | h;
    m_mask = (m_mask | ms) & ~mc;
    m_prev = p;
    m_primed = 1'b1;
    @(negedge clk);
    wv = 1'b0;
    chk_all(tag);
  endtask

  task automatic wr(string tag, logic [AW-1:0] a, logic [N-1:0] d);
    cyc(tag, pin, 1'b1, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin = '1; trig = '1; wv = 1'b0; wa = '0; wd = '0;
    m_stat = '0; m_mask = '1; m_prev = '0; m_primed = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("R1");
    rst_n = 1'b1;
    cyc("R13", '1, 1'b0, '0, '0);          // level at release is no edge
    chk_all("R1");
    cyc("R10", '0, 1'b0, '0, '0);          // falls latch while all masked
    wr("R13", 12'h000, '1);
    wr("R13", 12'h084, '1);
    wr("R8", A_MC, 32'h0000_00FF);
    wr("R9", A_ST, 32'h0000_000F);         // irq held by remaining bits
    wr("R9", A_ST, 32'h0000_00F0);
    wr("R7", A_MS, 32'h0000_000F);
    wr("R6", A_ST, '1);
    wr("R8", A_MC, '1);

    // sweep every trigger code over both directions on all pins
    for (int c = 0; c < 4; c++) begin
      string t;
      t = (c == 0) ? "R5" : (c == 1) ? "R2" : (c == 2) ? "R3" : "R4";
      for (int i = 0; i < N; i++) trig[2*i +: 2] = 2'(c);
      cyc(t, '1, 1'b0, '0, '0);
      wr("R6", A_ST, '1);
      cyc(t, '0, 1'b0, '0, '0);
      wr("R6", A_ST, '1);
    end

    // mixed codes, pin i uses code i mod 4
    for (int i = 0; i < N; i++) trig[2*i +: 2] = 2'(i % 4);
    cyc("R4", 32'hA5A5_0F0F, 1'b0, '0, '0);
    cyc("R4", 32'h5A5A_F0F0, 1'b0, '0, '0);
    wr("R6", A_ST, 32'h3C3C_3C3C);
    cyc("R4", '1, 1'b0, '0, '0);
    wr("R6", A_ST, '1);

    // walking single edges with rearm after clear
    trig = {N{2'b01}};
    cyc("R2", '0, 1'b0, '0, '0);
    for (int p = 0; p < N; p++) begin
      cyc("R12", N'(1) << p, 1'b0, '0, '0);
      cyc("R2", '0, 1'b0, '0, '0);
      wr("R6", A_ST, N'(1) << p);
      cyc("R12", N'(1) << p, 1'b0, '0, '0);
      cyc("R2", '0, 1'b0, '0, '0);
      wr("R6", A_ST, '1);
    end

    // edge and clear in the same cycle
    cyc("R11", '1, 1'b1, A_ST, '1);
    wr("R6", A_ST, '1);

    // latch under mask, then unmask
    trig = '1;
    wr("R7", A_MS, '1);
    cyc("R10", 32'h0000_FFFF, 1'b0, '0, '0);
    wr("R10", A_MC, 32'h0001_0000);
    wr("R10", A_MC, 32'h0000_0100);
    wr("R9", A_ST, '1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule